// File: doc/BRIEF.md
# Block Transfer Sequencer with Abort Suppression

This block steps through a multi-register load or store. A start pulse supplies four things: a 16-bit register list, the base value, the index of the base register, and two flags (load versus store, and writeback). The sequencer then visits every set bit of the list from the lowest index to the highest. For each one it presents a word address and waits for the memory handshake. During a load, each completed transfer raises a register write enable for the register being transferred. If writeback is requested, a final cycle writes the address just past the last word into the base register.

A data-abort input is sampled on every completed transfer. Once an abort is seen, the sequence does not stop early. Every remaining transfer still runs, so the instruction always takes the same number of transfer cycles. All register writes from the aborting transfer onward are suppressed. This keeps a base register that appears in the list, and register 15 (always the last to transfer), from being overwritten by loaded data. The base writeback still takes place. A sticky abort flag reports the outcome alongside a one-cycle done pulse.

The controller is a four-state machine:
- ST_IDLE waits for start.
- ST_XFER performs the transfers.
- ST_WBACK performs the base update.
- ST_DONE raises done.

Transitions:
- ST_IDLE→ST_XFER: start with a non-empty list.
- ST_IDLE→ST_DONE: start with an empty list.
- ST_XFER→ST_WBACK: last transfer completes and writeback is set.
- ST_XFER→ST_DONE: last transfer completes and writeback is clear.
- ST_WBACK→ST_DONE: always.
- ST_DONE→ST_IDLE: always.

Start is accepted only in ST_IDLE.

Top module: `blk_xfer_seq`

## Requirements
- R1: Registers are transferred one per set bit of the list, in ascending index order. `xfer_idx_o` shows the lowest index not yet transferred. A transfer completes only in a cycle where `mem_ack_i` is high; otherwise `mem_req_o` stays high with the same index and address.
- R2: The address of the k-th transfer (k counted from 0) is the base value plus 4·k.
- R3: During transfers, `mem_we_o` is 1 for a store (`is_load_i`=0) and 0 for a load.
- R4: For a load with no abort seen so far, `reg_we_o` is 1 in each cycle that completes a transfer, and `reg_widx_o` equals the transferred index. For a store, `reg_we_o` stays 0.
- R5: `abort_i` counts only in a cycle where a transfer completes. From that transfer onward, `reg_we_o` stays 0 until the sequence ends, including transfers of the base register and of register 15. `abort_i` in a cycle without `mem_ack_i` has no effect.
- R6: After an abort, every remaining transfer of the list is still requested and completed.
- R7: With writeback set and a non-empty list, one cycle after the last transfer `base_we_o` is 1 for exactly one cycle. In that cycle `base_widx_o` is the base index and `base_wval_o` is the base plus 4·(number of set bits). This happens even after an abort. With writeback clear, `base_we_o` stays 0.
- R8: `done_o` is a one-cycle pulse in the cycle after the last transfer, or after the writeback cycle if there is one. `abort_o` is 1 with done if any counted abort occurred, and holds its value until the next accepted start clears it.
- R9: An empty list gives `done_o` in the cycle after start, with no memory request and no writeback.
- R10: After reset, `busy_o`, `mem_req_o`, `reg_we_o`, `base_we_o`, `done_o` and `abort_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted in idle |
| reglist_i | input | 16 | Register list, bit i selects register i |
| base_idx_i | input | 4 | Index of the base register |
| base_val_i | input | 32 | Base address value |
| is_load_i | input | 1 | 1 = load, 0 = store |
| wback_i | input | 1 | Write the final address back to the base register |
| mem_ack_i | input | 1 | Current transfer completes this cycle |
| abort_i | input | 1 | Data abort for the completing transfer |
| mem_req_o | output | 1 | Transfer requested |
| mem_addr_o | output | 32 | Word address of the current transfer |
| mem_we_o | output | 1 | Current transfer is a store |
| xfer_idx_o | output | 4 | Register index of the current transfer |
| reg_we_o | output | 1 | Register file write enable (loads) |
| reg_widx_o | output | 4 | Register file write index |
| base_we_o | output | 1 | Base writeback enable |
| base_widx_o | output | 4 | Base writeback register index |
| base_wval_o | output | 32 | Base writeback value |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| abort_o | output | 1 | Sticky abort result |

## Verification
Request, address, index and write-enable outputs depend on the registered state plus same-cycle `mem_ack_i` and `abort_i`. The bench therefore drives those inputs after a falling edge and checks these outputs 2 ns later, in the same cycle.

The base writeback is due one cycle after the edge that completes the last transfer. Done comes one cycle after that when writeback is on; otherwise done comes one cycle after the last transfer. For an empty list, done comes one cycle after the start edge.

The bench walks its own model of the remaining list cycle by cycle. It checks each of these results only in the cycle where it is due, and checks one cycle after done that the done pulse has ended and the abort flag has held.

// File: rtl/bxs_pkg.sv
package bxs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_WBACK = 2'd2,
        ST_DONE  = 2'd3
    } bxs_state_e;

    localparam int WORD_SHIFT = 2;
endpackage

// File: rtl/bxs_prienc.sv
module bxs_prienc #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec_i,
    output logic [IW-1:0] idx_o,
    output logic [N-1:0]  low_o
);
    logic [N-1:0] hit;

    // isolate the lowest set bit
    assign low_o = vec_i & (~vec_i + N'(1));

    generate
        for (genvar g = 0; g < N; g++) begin : g_hit
            assign hit[g] = low_o[g];
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/bxs_addr_gen.sv
module bxs_addr_gen #(
    parameter int AW = 32,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] base_i,
    input  logic          step_i,
    output logic [AW-1:0] addr_o
);
    import bxs_pkg::*;

    logic [AW-1:0] base_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load_i) begin
            base_q <= base_i;
            cnt_q  <= '0;
        end else if (step_i) begin
            cnt_q  <= cnt_q + CW'(1);
        end
    end

    assign addr_o = base_q + (AW'(cnt_q) << WORD_SHIFT);
endmodule

// File: rtl/bxs_abort_track.sv
module bxs_abort_track (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic set_i,
    output logic flag_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_o <= 1'b0;
        else if (clear_i) flag_o <= 1'b0;
        else if (set_i)   flag_o <= 1'b1;
    end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
    parameter int NREG = 16,
    parameter int AW   = 32,
    localparam int IW  = $clog2(NREG),
    localparam int CW  = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NREG-1:0] reglist_i,
    input  logic [IW-1:0]   base_idx_i,
    input  logic [AW-1:0]   base_val_i,
    input  logic            is_load_i,
    input  logic            wback_i,
    input  logic            mem_ack_i,
    input  logic            abort_i,
    output logic            mem_req_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic            mem_we_o,
    output logic [IW-1:0]   xfer_idx_o,
    output logic            reg_we_o,
    output logic [IW-1:0]   reg_widx_o,
    output logic            base_we_o,
    output logic [IW-1:0]   base_widx_o,
    output logic [AW-1:0]   base_wval_o,
    output logic            busy_o,
    output logic            done_o,
    output logic            abort_o
);
    import bxs_pkg::*;

    bxs_state_e      state_q, state_d;
    logic [NREG-1:0] list_q;
    logic            ld_q, wb_q;
    logic [IW-1:0]   bidx_q;
    logic [IW-1:0]   cur_idx;
    logic [NREG-1:0] low_bit;
    logic [AW-1:0]   cur_addr;
    logic            accept, xfer_go, last_xfer, abort_seen;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign xfer_go   = (state_q == ST_XFER) && mem_ack_i;
    assign last_xfer = ((list_q & ~low_bit) == '0);

    bxs_prienc #(.N(NREG), .IW(IW)) u_prienc (
        .vec_i (list_q),
        .idx_o (cur_idx),
        .low_o (low_bit)
    );

    bxs_addr_gen #(.AW(AW), .CW(CW)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .base_i (base_val_i),
        .step_i (xfer_go),
        .addr_o (cur_addr)
    );

    bxs_abort_track u_abort (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .set_i   (xfer_go && abort_i),
        .flag_o  (abort_seen)
    );

    // state register and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            list_q  <= '0;
            ld_q    <= 1'b0;
            wb_q    <= 1'b0;
            bidx_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                list_q <= reglist_i;
                ld_q   <= is_load_i;
                wb_q   <= wback_i;
                bidx_q <= base_idx_i;
            end else if (xfer_go) begin
                list_q <= list_q & ~low_bit;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = (reglist_i == '0) ? ST_DONE : ST_XFER;
            ST_XFER:  if (xfer_go && last_xfer) state_d = wb_q ? ST_WBACK : ST_DONE;
            ST_WBACK: state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        reg_we_o    = 1'b0;
        base_we_o   = 1'b0;
        done_o      = 1'b0;
        mem_addr_o  = cur_addr;
        xfer_idx_o  = cur_idx;
        reg_widx_o  = cur_idx;
        base_widx_o = bidx_q;
        base_wval_o = cur_addr;
        busy_o      = (state_q != ST_IDLE);
        abort_o     = abort_seen;
        unique case (state_q)
            ST_IDLE:  ;
            ST_XFER: begin
                mem_req_o = 1'b1;
                mem_we_o  = !ld_q;
                reg_we_o  = xfer_go && ld_q && !abort_i && !abort_seen;
            end
            ST_WBACK: base_we_o = 1'b1;
            ST_DONE:  done_o = 1'b1;
            default:  ;
        endcase
    end

    AST_IDX_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i) |=> (!mem_req_o || xfer_idx_o > $past(xfer_idx_o))); // R1
    AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(xfer_idx_o))); // R1
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_ack_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + AW'(4))); // R2
    AST_WE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (mem_req_o && mem_ack_i && !abort_i)); // R4
    AST_NO_WE_AFTER_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !reg_we_o); // R5
    AST_WB_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        base_we_o |=> (done_o && !base_we_o)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !start_i) |=> abort_o); // R8
endmodule

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] reglist_i = '0;
    logic [3:0]  base_idx_i = '0;
    logic [31:0] base_val_i = '0;
    logic        is_load_i = 1'b0, wback_i = 1'b0, mem_ack_i = 1'b0, abort_i = 1'b0;
    logic        mem_req_o, mem_we_o, reg_we_o, base_we_o, busy_o, done_o, abort_o;
    logic [31:0] mem_addr_o, base_wval_o;
    logic [3:0]  xfer_idx_o, reg_widx_o, base_widx_o;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    blk_xfer_seq dut_i (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return 0;
    endfunction

    // abort_at: transfer position that aborts, -1 for none; noisy: drive abort_i without ack
    task automatic do_op(input logic [15:0] list, input logic [3:0] bidx, input logic [31:0] bval,
                         input bit ld, input bit wb, input int abort_at, input bit noisy);
        logic [15:0] rem = list;
        int pos = 0;
        bit ab = 0;
        @(negedge clk);
        start_i = 1; reglist_i = list; base_idx_i = bidx; base_val_i = bval;
        is_load_i = ld; wback_i = wb;
        @(negedge clk);
        start_i = 0; reglist_i = $urandom; base_val_i = $urandom;
        while (rem != 0) begin
            bit ack = ($urandom % 4) != 0;
            bit abt = ack ? (pos == abort_at) : (noisy && ($urandom % 2 == 0));
            bit exp_we = ld && ack && !ab && !(ack && abt);
            mem_ack_i = ack; abort_i = abt;
            #2;
            chk(mem_req_o === 1'b1, "R1 req", 32'(mem_req_o), 1);
            chk(xfer_idx_o === 4'(lowest(rem)), ab ? "R6 idx" : "R1 idx", 32'(xfer_idx_o), lowest(rem));
            chk(mem_addr_o === bval + 32'(4 * pos), "R2 addr", mem_addr_o, bval + 32'(4 * pos));
            chk(mem_we_o === !ld, "R3 we", 32'(mem_we_o), 32'(!ld));
            chk(reg_we_o === exp_we, ab || abt ? "R5 reg_we" : "R4 reg_we", 32'(reg_we_o), 32'(exp_we));
            if (exp_we) chk(reg_widx_o === 4'(lowest(rem)), "R4 widx", 32'(reg_widx_o), lowest(rem));
            if (ack) begin
                if (abt) ab = 1;
                rem[lowest(rem)] = 1'b0;
                pos++;
            end
            @(negedge clk);
        end
        mem_ack_i = 0; abort_i = 0;
        if (wb && list != 0) begin
            #2;
            chk(base_we_o === 1'b1, "R7 base_we", 32'(base_we_o), 1);
            chk(base_wval_o === bval + 32'(4 * pos), "R7 wval", base_wval_o, bval + 32'(4 * pos));
            chk(base_widx_o === bidx, "R7 widx", 32'(base_widx_o), 32'(bidx));
            chk(mem_req_o === 1'b0, "R7 req", 32'(mem_req_o), 0);
            @(negedge clk);
        end
        #2;
        chk(done_o === 1'b1, list == 0 ? "R9 done" : "R8 done", 32'(done_o), 1);
        chk(abort_o === ab, "R8 abort", 32'(abort_o), 32'(ab));
        chk(base_we_o === 1'b0, "R7 no_wb", 32'(base_we_o), 0);
        chk(mem_req_o === 1'b0, "R9 req", 32'(mem_req_o), 0);
        @(negedge clk);
        #2;
        chk(done_o === 1'b0, "R8 pulse", 32'(done_o), 0);
        chk(abort_o === ab, "R8 sticky", 32'(abort_o), 32'(ab));
        chk(busy_o === 1'b0, "R8 idle", 32'(busy_o), 0);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        #12;
        chk(busy_o === 0 && mem_req_o === 0 && done_o === 0, "R10 reset", 32'(busy_o), 0);
        chk(reg_we_o === 0 && base_we_o === 0 && abort_o === 0, "R10 reset", 32'(abort_o), 0);
        rst_n = 1;
        // R9 empty list, with writeback requested
        do_op(16'h0000, 4'd3, 32'h100, 1, 1, -1, 0);
        // R5 base in list, abort at first transfer, full list, R15 last
        do_op(16'hFFFF, 4'd4, 32'h2000, 1, 1, 0, 0);
        // R5 abort on the final (R15) transfer
        do_op(16'h8011, 4'd0, 32'h40, 1, 0, 2, 0);
        // R4 load with base in list, no abort, writeback after
        do_op(16'h00F0, 4'd5, 32'h1000, 1, 1, -1, 0);
        // R3 store with abort mid-way; R6 rest still runs
        do_op(16'h0F0F, 4'd1, 32'h3000, 0, 1, 3, 0);
        // R5 abort_i without ack ignored
        do_op(16'h1234, 4'd2, 32'h500, 1, 0, -1, 1);
        // R8 flag cleared by next start
        do_op(16'h0001, 4'd0, 32'h8, 1, 0, -1, 0);
        for (int k = 0; k < 60; k++) begin
            logic [15:0] l = 16'($urandom);
            int cnt = $countones(l);
            int at = ($urandom % 2 == 0 && cnt > 0) ? int'($urandom % cnt) : -1;
            do_op(l, 4'($urandom), $urandom & 32'hFFFF_FFFC, $urandom % 2, $urandom % 2, at, $urandom % 2);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule